// File: doc/BRIEF.md
# Flash Address-Window Permission Checker

This block sits between the bus and a flash array and decides, for every access, whether it may proceed. A small bank of configuration registers defines a set of address windows. Each window has a base address, a size field that holds the window length minus one, and a control field with three bits: one switches the window on, one permits reads, and one permits program or erase requests. An incoming access is compared against every window in parallel. It is allowed when at least one switched-on, well-formed window that contains the address carries the matching permission bit.

A window is only well formed when its length is a power of two, its base is a multiple of that length, and its last byte lies below the end of the protected space. A window that breaks any of these rules grants nothing. Windows may overlap, and permissions from overlapping windows combine. An access that no window permits is blocked, and the block raises a sticky violation flag that stays set until software writes a dedicated clear address.

Top module: `flash_guard`

## Requirements
- R1: After reset every window is switched off, every access is blocked and the violation flag reads 0.
- R2: Configuration writes place window i's base at offset 8*i, its size at 8*i+4 and its control at 8*N+4*i (N windows); the control field holds enable in bit 0, read permission in bit 1 and write permission in bit 2. A write takes effect from the next cycle.
- R3: An address falls in a window when it is at or above the base and at or below base plus the size field.
- R4: A read is allowed exactly when some enabled, well-formed window containing the address has its read bit set.
- R5: A program or erase access is allowed exactly when some enabled, well-formed window containing the address has its write bit set.
- R6: A window whose enable bit is 0 grants nothing, whatever its read and write bits hold.
- R7: A window whose size field plus one is not a power of two grants nothing.
- R8: A window whose base is not a multiple of its length grants nothing.
- R9: A window whose last byte lies at or past the protected-space limit grants nothing.
- R10: A valid access that is not allowed sets the violation flag one cycle later, and the flag then holds until cleared.
- R11: A configuration write to offset 12*N clears the flag one cycle later; a blocked access in the same cycle wins and leaves it set.
- R12: Rewriting a window's control with only the write bit removed blocks writes in that window while reads stay allowed.
- R13: When no access is presented the allow output is 0 and the flag does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_write | input | 1 | 1 for program or erase, 0 for read |
| acc_allow | output | 1 | Access permitted (combinational) |
| viol_flag | output | 1 | Sticky violation flag |

## Verification
A wrong window register or a broken shape check shows at once on acc_allow, in the same cycle the access is presented, and usually as a whole contiguous band of addresses granted or refused; the bench therefore sweeps every address for reads and writes under several window sets and compares each result against an arithmetic model. A wrong flag state appears one cycle after the offending or clearing event, so flag checks sample just after that edge, including the cycle where a block and a clear coincide.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    // Control field: bit 0 enable, bit 1 read, bit 2 write.
    typedef struct packed {
        logic wr;
        logic rd;
        logic en;
    } fg_ctrl_t;

    localparam int CTRL_BITS = 3;

    // Register kinds decoded from a configuration offset.
    typedef enum logic [1:0] {
        FG_REG_NONE,
        FG_REG_BASE,
        FG_REG_SIZE,
        FG_REG_CTRL
    } fg_reg_kind_e;

    // Window shape rules on up-to-32-bit operands.
    function automatic logic fg_len_pow2(input logic [32:0] sz);
        return ((sz & (sz + 33'd1)) == 33'd0);
    endfunction

    function automatic logic fg_aligned(input logic [32:0] base, input logic [32:0] sz);
        return ((base & sz) == 33'd0);
    endfunction

endpackage

// File: rtl/fg_regfile.sv
module fg_regfile
    import flash_guard_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int ADDR_W  = 12,
    parameter int CFG_AW  = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             cfg_we,
    input  logic [CFG_AW-1:0]                cfg_addr,
    input  logic [31:0]                      cfg_wdata,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]   base_q,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]   size_q,
    output fg_ctrl_t [NUM_WIN-1:0]           ctrl_q,
    output logic                             clr_pulse
);
    localparam int CTRL_OFS = NUM_WIN * 8;
    localparam int CLR_OFS  = NUM_WIN * 12;

    assign clr_pulse = cfg_we && (cfg_addr == CFG_AW'(CLR_OFS));

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        fg_reg_kind_e kind;

        always_comb begin
            if (cfg_addr == CFG_AW'(i * 8))
                kind = FG_REG_BASE;
            else if (cfg_addr == CFG_AW'(i * 8 + 4))
                kind = FG_REG_SIZE;
            else if (cfg_addr == CFG_AW'(CTRL_OFS + i * 4))
                kind = FG_REG_CTRL;
            else
                kind = FG_REG_NONE;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[i] <= '0;
                size_q[i] <= '0;
                ctrl_q[i] <= '0;
            end else if (cfg_we) begin
                case (kind)
                    FG_REG_BASE: base_q[i] <= cfg_wdata[ADDR_W-1:0];
                    FG_REG_SIZE: size_q[i] <= cfg_wdata[ADDR_W-1:0];
                    FG_REG_CTRL: ctrl_q[i] <= fg_ctrl_t'(cfg_wdata[CTRL_BITS-1:0]);
                    default: ;
                endcase
            end
        end

        AST_CTRL_LOADS: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && cfg_addr == CFG_AW'(CTRL_OFS + i * 4))
            |=> (ctrl_q[i] == $past(cfg_wdata[CTRL_BITS-1:0]))); // R2
    end

endmodule

// File: rtl/fg_window.sv
module fg_window
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int SPACE_LIMIT = 3072
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] size,
    input  fg_ctrl_t          ctrl,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_ok,
    output logic              wr_ok
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(SPACE_LIMIT);

    logic [ADDR_W:0] last_byte;
    logic            shape_ok;
    logic            hit;

    always_comb begin
        last_byte = {1'b0, base} + {1'b0, size};
        shape_ok  = fg_len_pow2(33'(size))
                 && fg_aligned(33'(base), 33'(size))
                 && (last_byte < LIMIT);
        hit       = (addr >= base) && ({1'b0, addr} <= last_byte);
        rd_ok     = ctrl.en && ctrl.rd && shape_ok && hit;
        wr_ok     = ctrl.en && ctrl.wr && shape_ok && hit;
    end

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en |-> !(rd_ok || wr_ok)); // R6

    AST_PAST_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (last_byte >= LIMIT) |-> !(rd_ok || wr_ok)); // R9

endmodule

// File: rtl/fg_fault.sv
module fg_fault (
    input  logic clk,
    input  logic rst,
    input  logic acc_valid,
    input  logic acc_allow,
    input  logic clr_pulse,
    output logic viol_flag
);
    logic blocked;

    assign blocked = acc_valid && !acc_allow;

    always_ff @(posedge clk) begin
        if (rst)
            viol_flag <= 1'b0;
        else if (blocked)
            viol_flag <= 1'b1;
        else if (clr_pulse)
            viol_flag <= 1'b0;
    end

    AST_BLOCK_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_allow) |=> viol_flag); // R10

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (viol_flag && !clr_pulse) |=> viol_flag); // R10

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr_pulse && !(acc_valid && !acc_allow)) |=> !viol_flag); // R11

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int NUM_WIN     = 4,
    parameter int ADDR_W      = 12,
    parameter int SPACE_LIMIT = 3072,
    parameter int CFG_AW      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    output logic              acc_allow,
    output logic              viol_flag
);
    logic [NUM_WIN-1:0][ADDR_W-1:0] base_q;
    logic [NUM_WIN-1:0][ADDR_W-1:0] size_q;
    fg_ctrl_t [NUM_WIN-1:0]         ctrl_q;
    logic                           clr_pulse;
    logic [NUM_WIN-1:0]             rd_vec;
    logic [NUM_WIN-1:0]             wr_vec;

    fg_regfile #(
        .NUM_WIN (NUM_WIN),
        .ADDR_W  (ADDR_W),
        .CFG_AW  (CFG_AW)
    ) regs_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .base_q    (base_q),
        .size_q    (size_q),
        .ctrl_q    (ctrl_q),
        .clr_pulse (clr_pulse)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_chk
        fg_window #(
            .ADDR_W      (ADDR_W),
            .SPACE_LIMIT (SPACE_LIMIT)
        ) win_i (
            .clk   (clk),
            .rst   (rst),
            .base  (base_q[i]),
            .size  (size_q[i]),
            .ctrl  (ctrl_q[i]),
            .addr  (acc_addr),
            .rd_ok (rd_vec[i]),
            .wr_ok (wr_vec[i])
        );
    end

    assign acc_allow = acc_valid && (acc_write ? (|wr_vec) : (|rd_vec));

    fg_fault fault_i (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_allow (acc_allow),
        .clr_pulse (clr_pulse),
        .viol_flag (viol_flag)
    );

    AST_IDLE_NO_ALLOW: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> !acc_allow); // R13

    AST_IDLE_FLAG_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid && !clr_pulse) |=> $stable(viol_flag)); // R13

endmodule

// File: tb/flash_guard_tb_top.sv
module flash_guard_tb_top;
    localparam int N      = 4;
    localparam int AW     = 12;
    localparam int LIM    = 3072;
    localparam int CAW    = 8;
    localparam int CTRLO  = N * 8;
    localparam int CLRO   = N * 12;
    localparam int EN = 1, RD = 2, WR = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_we = 1'b0;
    logic [CAW-1:0] cfg_addr = '0;
    logic [31:0]    cfg_wdata = '0;
    logic           acc_valid = 1'b0;
    logic [AW-1:0]  acc_addr = '0;
    logic           acc_write = 1'b0;
    logic           acc_allow;
    logic           viol_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int mb[N];
    int ms[N];
    int mc[N];

    always #2.5 clk = ~clk;

    flash_guard #(.NUM_WIN(N), .ADDR_W(AW), .SPACE_LIMIT(LIM), .CFG_AW(CAW)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_allow(acc_allow), .viol_flag(viol_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d time=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic cfg_wr(input int ofs, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = CAW'(ofs); cfg_wdata = 32'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_win(input int i, input int b, input int s, input int c);
        cfg_wr(i * 8, b);
        cfg_wr(i * 8 + 4, s);
        cfg_wr(CTRLO + i * 4, c);
        mb[i] = b; ms[i] = s; mc[i] = c;
    endtask

    function automatic int model(input int a, input bit w);
        int r = 0;
        for (int i = 0; i < N; i++) begin
            bit ok;
            ok = ((ms[i] & (ms[i] + 1)) == 0) && ((mb[i] % (ms[i] + 1)) == 0)
              && (mb[i] + ms[i] < LIM) && ((mc[i] & EN) != 0)
              && (a >= mb[i]) && (a <= mb[i] + ms[i]);
            if (ok && ((mc[i] & (w ? WR : RD)) != 0)) r = 1;
        end
        return r;
    endfunction

    task automatic probe(input int a, input bit w, input int exp, input string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = AW'(a); acc_write = w;
        #1;
        check(tag, int'(acc_allow), exp);
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < (1 << AW); a++) begin
            for (int w = 0; w < 2; w++) begin
                probe(a, w[0], model(a, w[0]), w ? {tag, " R5"} : {tag, " R4"});
            end
        end
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin mb[i] = 0; ms[i] = 0; mc[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1 flag", int'(viol_flag), 0);
        probe(0, 1'b0, 0, "R1 read blocked");
        probe(12, 1'b1, 0, "R1 write blocked");
        @(negedge clk); acc_valid = 1'b0;
        cfg_wr(CLRO, 0);

        // R13: idle access
        @(negedge clk); acc_valid = 1'b0; acc_addr = '0; #1;
        check("R13 idle allow", int'(acc_allow), 0);
        @(posedge clk); #1;
        check("R13 idle flag", int'(viol_flag), 0);

        // Set A: R2 layout, R3 bounds, R6 off, R7 bad length
        set_win(0, 'h000, 'h0FF, EN | RD | WR);
        set_win(1, 'h400, 'h3FF, EN | RD);
        set_win(2, 'h100, 'h0FF, RD | WR);
        set_win(3, 'h800, 'h2FF, EN | RD | WR);
        probe('h0FF, 1'b1, 1, "R3 last byte");
        probe('h100, 1'b1, 0, "R3 past end");
        probe('h3FF, 1'b0, 0, "R3 below base");
        probe('h400, 1'b0, 1, "R2 R3 base byte");
        probe('h180, 1'b0, 0, "R6 disabled");
        probe('h900, 1'b0, 0, "R7 bad length");
        sweep("setA");

        // Set B: R8 misaligned, R9 past limit, overlap
        set_win(0, 'h000, 'h7FF, EN | RD);
        set_win(1, 'h200, 'h1FF, EN | WR);
        set_win(2, 'h180, 'h0FF, EN | RD | WR);
        set_win(3, 'h800, 'h7FF, EN | RD | WR);
        probe('h200, 1'b1, 1, "R5 overlap write");
        probe('h200, 1'b0, 1, "R4 overlap read");
        probe('h190, 1'b1, 0, "R8 misaligned");
        probe('h900, 1'b0, 0, "R9 past limit");
        sweep("setB");

        // R12: drop only the write bit
        set_win(1, 'h400, 'h3FF, EN | RD | WR);
        probe('h500, 1'b1, 1, "R12 write before");
        cfg_wr(CTRLO + 4, EN | RD); mc[1] = EN | RD;
        probe('h500, 1'b1, 0, "R12 write revoked");
        probe('h500, 1'b0, 1, "R12 read kept");

        // R10 / R11 flag behaviour
        @(negedge clk); acc_valid = 1'b0;
        cfg_wr(CLRO, 0);
        #1; check("R11 cleared", int'(viol_flag), 0);
        probe('h500, 1'b0, 1, "R10 allowed access");
        @(posedge clk); #1;
        check("R10 no flag on allowed", int'(viol_flag), 0);
        probe('hB00, 1'b0, 0, "R10 blocked access");
        @(posedge clk); #1;
        check("R10 flag set", int'(viol_flag), 1);
        @(negedge clk); acc_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 sticky", int'(viol_flag), 1);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = CAW'(CLRO);
        acc_valid = 1'b1; acc_addr = 'hB00; acc_write = 1'b0;
        @(posedge clk); #1;
        check("R11 block beats clear", int'(viol_flag), 1);
        @(negedge clk); acc_valid = 1'b0;
        @(posedge clk); #1;
        check("R11 clear", int'(viol_flag), 0);
        @(negedge clk); cfg_we = 1'b0;
        cfg_wr(CLRO - 4, EN | RD | WR);
        #1; check("R2 near-clear offset keeps flag", int'(viol_flag), 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule